// File: doc/BRIEF.md
# Tri-Level Sync Format Detector

This block sits behind two sliced sync comparators. One bit is high while the incoming video is below blanking (the negative sync tip). The other is high while it is above blanking (the positive half of a tri-level sync). From the timing of these two bits, the block decides whether the source carries high-definition tri-level sync or ordinary bi-level sync. Bi-level sources include standard-definition, enhanced-definition and computer graphics timings.

It also times the interval between successive negative sync leading edges. That interval gives a coarse line-rate class and a lock indication. The active-low HD flag falls only after a long unbroken run of tri-level lines, so a few odd lines cannot toggle an external filter switch. If the input disappears or changes, the block falls back to its default state by itself. It then qualifies the new input without any reset.

Top module: `tls_format_detector`

## Requirements
- R1: While reset is asserted and in the first cycle after reset, hd_n is 1, fmt_code is 0 and locked is 0.
- R2: A rising edge of neg_sync (a 0 sample followed by a 1 sample) starts a line, and the next such edge ends it. A line counts as tri-level only if pos_sync rises between 1 and WIN clock edges after the edge that started it. A rise at offset WIN+1 or later, or none at all, makes the line bi-level.
- R3: hd_n goes low only after HD_LINES consecutive completed tri-level lines, and no earlier.
- R4: Bi-level lines never drive hd_n low, at any line rate, including computer graphics rates.
- R5: Once hd_n is low, it returns high after BI_LINES consecutive completed bi-level lines. Fewer than that leave it low.
- R6: If no neg_sync rising edge arrives for TIMEOUT cycles after the last one, the block returns by itself to hd_n=1, locked=0 and fmt_code=0. The next edge then starts a fresh qualification.
- R7: fmt_code reflects the period P, in clock cycles, of the most recent completed line: 1 when P >= SLOW_MIN, 2 when MID_MIN <= P < SLOW_MIN, and 3 when P < MID_MIN. A value of 0 means no line has been measured since reset or loss.
- R8: locked rises once LOCK_LINES consecutive completed lines each differ from the line before by at most TOL cycles. The first line after start or loss only sets the reference.
- R9: A completed line whose period differs from the previous one by more than TOL cycles clears locked and restarts the stable count.
- R10: All outputs update on the second clock edge after the neg_sync rising edge that completes a line, and they hold between line completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| neg_sync | input | 1 | Sliced bit, high while input is below blanking |
| pos_sync | input | 1 | Sliced bit, high while input is above the positive sync slice |
| hd_n | output | 1 | Low when a qualified tri-level input is present |
| fmt_code | output | 2 | Line-rate class: 0 none, 1 slow, 2 medium, 3 fast |
| locked | output | 1 | High when the line period has been stable |

## Verification
A run counter that fails to clear shows up as hd_n changing one or more lines too early or too late. A wrong tri/bi decision per line shows the same way, and both are visible at the exact line where the threshold is crossed. A stale reference period shows up as locked rising or dropping on the wrong line after a period step. A missed loss event leaves hd_n low or fmt_code nonzero after the idle interval. The line-by-line reference in the bench exposes each of these faults within the line where it first matters. It also exposes any one-cycle slip in output timing.

// File: rtl/tls_pkg.sv
package tls_pkg;

  localparam logic [1:0] FMT_NONE = 2'd0;
  localparam logic [1:0] FMT_SLOW = 2'd1;
  localparam logic [1:0] FMT_MID  = 2'd2;
  localparam logic [1:0] FMT_FAST = 2'd3;

  // map a measured line period to a coarse rate class
  function automatic logic [1:0] period_bin(input int unsigned p,
                                            input int unsigned slow_min,
                                            input int unsigned mid_min);
    if (p >= slow_min)     return FMT_SLOW;
    else if (p >= mid_min) return FMT_MID;
    else                   return FMT_FAST;
  endfunction

  // magnitude of the difference between two periods
  function automatic int unsigned abs_diff(input int unsigned a,
                                           input int unsigned b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

endpackage

// File: rtl/tls_edge_tracker.sv
module tls_edge_tracker #(
  parameter int WIN     = 8,
  parameter int TIMEOUT = 1000,
  parameter int CNT_W   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             neg_sync,
  input  logic             pos_sync,
  output logic             line_done,
  output logic             line_tri,
  output logic [CNT_W-1:0] line_period,
  output logic             loss
);

  localparam logic [CNT_W-1:0] WIN_C = CNT_W'(WIN);
  localparam logic [CNT_W-1:0] TMO_C = CNT_W'(TIMEOUT);

  logic             neg_q, pos_q, started, tri_seen;
  logic [CNT_W-1:0] age;
  logic             neg_rise, pos_rise, in_window;

  assign neg_rise  = neg_sync & ~neg_q;
  assign pos_rise  = pos_sync & ~pos_q;
  assign in_window = started && (age != '0) && (age <= WIN_C);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      neg_q       <= 1'b0;
      pos_q       <= 1'b0;
      started     <= 1'b0;
      tri_seen    <= 1'b0;
      age         <= '0;
      line_done   <= 1'b0;
      line_tri    <= 1'b0;
      line_period <= '0;
      loss        <= 1'b0;
    end else begin
      neg_q     <= neg_sync;
      pos_q     <= pos_sync;
      line_done <= 1'b0;
      loss      <= 1'b0;
      if (neg_rise) begin
        line_done   <= started;
        line_tri    <= tri_seen;
        line_period <= age;
        age         <= CNT_W'(1);
        tri_seen    <= 1'b0;
        started     <= 1'b1;
      end else begin
        if (age < TMO_C) age <= age + 1'b1;
        if (pos_rise && in_window) tri_seen <= 1'b1;
        if (started && age == TMO_C) begin
          loss    <= 1'b1;
          started <= 1'b0;
        end
      end
    end
  end

  // R6: a line completion and a loss event never coincide
  p_done_loss_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({line_done, loss}));

  // R2: a measured period never exceeds the loss limit
  p_period_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> (line_period <= TMO_C && line_period != '0));

endmodule

// File: rtl/tls_hd_qualifier.sv
module tls_hd_qualifier #(
  parameter int HD_LINES = 16,
  parameter int BI_LINES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_done,
  input  logic line_tri,
  input  logic loss,
  output logic hd
);

  localparam int TRI_W = $clog2(HD_LINES + 1);
  localparam int BI_W  = $clog2(BI_LINES + 1);
  localparam logic [TRI_W-1:0] TRI_MAX = TRI_W'(HD_LINES);
  localparam logic [TRI_W-1:0] TRI_M1  = TRI_W'(HD_LINES - 1);
  localparam logic [BI_W-1:0]  BI_MAX  = BI_W'(BI_LINES);
  localparam logic [BI_W-1:0]  BI_M1   = BI_W'(BI_LINES - 1);

  logic [TRI_W-1:0] tri_run;
  logic [BI_W-1:0]  bi_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tri_run <= '0;
      bi_run  <= '0;
      hd      <= 1'b0;
    end else if (loss) begin
      tri_run <= '0;
      bi_run  <= '0;
      hd      <= 1'b0;
    end else if (line_done) begin
      if (line_tri) begin
        bi_run <= '0;
        if (tri_run < TRI_MAX) tri_run <= tri_run + 1'b1;
        if (tri_run >= TRI_M1) hd <= 1'b1;
      end else begin
        tri_run <= '0;
        if (bi_run < BI_MAX) bi_run <= bi_run + 1'b1;
        if (bi_run >= BI_M1) hd <= 1'b0;
      end
    end
  end

  // R3: the flag only sets on a tri-level line completion
  p_hd_set_on_tri_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hd) |-> $past(line_done && line_tri));

  // R5: the flag only clears on loss or a bi-level completion
  p_hd_clear_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hd) |-> $past(loss || (line_done && !line_tri)));

  // R4: a bi-level line never sets the flag
  p_bi_no_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (line_done && !line_tri && !loss && !hd) |=> !hd);

endmodule

// File: rtl/tls_lock_tracker.sv
module tls_lock_tracker
  import tls_pkg::*;
#(
  parameter int CNT_W      = 10,
  parameter int TOL        = 4,
  parameter int LOCK_LINES = 24,
  parameter int SLOW_MIN   = 400,
  parameter int MID_MIN    = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_done,
  input  logic [CNT_W-1:0] line_period,
  input  logic             loss,
  output logic             locked,
  output logic [1:0]       fmt
);

  localparam int STB_W = $clog2(LOCK_LINES + 1);
  localparam logic [STB_W-1:0] STB_MAX = STB_W'(LOCK_LINES);
  localparam logic [STB_W-1:0] STB_M1  = STB_W'(LOCK_LINES - 1);

  logic             have_prev;
  logic [CNT_W-1:0] prev;
  logic [STB_W-1:0] stable;
  logic             jump;

  assign jump = abs_diff(32'(line_period), 32'(prev)) > 32'(TOL);

  always_ff @(posedge clk) begin
    if (!rst_n || loss) begin
      have_prev <= 1'b0;
      prev      <= '0;
      stable    <= '0;
      locked    <= 1'b0;
      fmt       <= FMT_NONE;
    end else if (line_done) begin
      fmt       <= period_bin(32'(line_period), 32'(SLOW_MIN), 32'(MID_MIN));
      prev      <= line_period;
      have_prev <= 1'b1;
      if (!have_prev || jump) begin
        stable <= '0;
        locked <= 1'b0;
      end else begin
        if (stable < STB_MAX) stable <= stable + 1'b1;
        if (stable >= STB_M1) locked <= 1'b1;
      end
    end
  end

  // R9: a period jump always leaves the tracker unlocked
  p_jump_unlocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (line_done && have_prev && jump) |=> !locked);

  // R8: lock only appears on an in-tolerance completion
  p_lock_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(line_done && have_prev && !jump));

  // R10: the class holds between completions
  p_fmt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_done && !loss) |=> $stable(fmt));

endmodule

// File: rtl/tls_format_detector.sv
module tls_format_detector #(
  parameter int WIN        = 8,
  parameter int TIMEOUT    = 1000,
  parameter int HD_LINES   = 16,
  parameter int BI_LINES   = 8,
  parameter int LOCK_LINES = 24,
  parameter int TOL        = 4,
  parameter int SLOW_MIN   = 400,
  parameter int MID_MIN    = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       neg_sync,
  input  logic       pos_sync,
  output logic       hd_n,
  output logic [1:0] fmt_code,
  output logic       locked
);

  localparam int CNT_W = $clog2(TIMEOUT + 1);

  logic             line_done, line_tri, loss, hd;
  logic [CNT_W-1:0] line_period;

  tls_edge_tracker #(.WIN(WIN), .TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) u_edges (
    .clk(clk), .rst_n(rst_n), .neg_sync(neg_sync), .pos_sync(pos_sync),
    .line_done(line_done), .line_tri(line_tri), .line_period(line_period),
    .loss(loss)
  );

  tls_hd_qualifier #(.HD_LINES(HD_LINES), .BI_LINES(BI_LINES)) u_qual (
    .clk(clk), .rst_n(rst_n), .line_done(line_done), .line_tri(line_tri),
    .loss(loss), .hd(hd)
  );

  tls_lock_tracker #(.CNT_W(CNT_W), .TOL(TOL), .LOCK_LINES(LOCK_LINES),
                     .SLOW_MIN(SLOW_MIN), .MID_MIN(MID_MIN)) u_lock (
    .clk(clk), .rst_n(rst_n), .line_done(line_done),
    .line_period(line_period), .loss(loss), .locked(locked), .fmt(fmt_code)
  );

  assign hd_n = ~hd;

  // R6: a loss event returns every output to its default
  p_loss_defaults_r6: assert property (@(posedge clk) disable iff (!rst_n)
    loss |=> (hd_n && !locked && fmt_code == 2'd0));

  // R8: lock implies a measured rate class
  p_lock_has_class_r8: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (fmt_code != 2'd0));

  // R1: defaults in the first cycle after reset
  p_reset_defaults_r1: assert property (@(posedge clk)
    $past(!rst_n) |-> (hd_n && !locked && fmt_code == 2'd0));

endmodule

// File: tb/tls_format_detector_test.sv
module tls_format_detector_test;

  localparam int CLK_PERIOD = 10;
  localparam int WIN = 8, TIMEOUT = 1000, HD_LINES = 16, BI_LINES = 8;
  localparam int LOCK_LINES = 24, TOL = 4, SLOW_MIN = 400, MID_MIN = 200;
  localparam int PW = 4;

  logic clk = 1'b0, rst_n = 1'b0, neg_sync = 1'b0, pos_sync = 1'b0;
  logic hd_n, locked;
  logic [1:0] fmt_code;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  // reference state
  bit m_started = 0, m_hd = 0, m_locked = 0, m_have_prev = 0, m_prev_tri = 0;
  int m_tri = 0, m_bi = 0, m_stable = 0, m_prev_p = 0, m_fmt = 0, m_last_p = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tls_format_detector #(.WIN(WIN), .TIMEOUT(TIMEOUT), .HD_LINES(HD_LINES),
    .BI_LINES(BI_LINES), .LOCK_LINES(LOCK_LINES), .TOL(TOL),
    .SLOW_MIN(SLOW_MIN), .MID_MIN(MID_MIN)) uut (
    .clk(clk), .rst_n(rst_n), .neg_sync(neg_sync), .pos_sync(pos_sync),
    .hd_n(hd_n), .fmt_code(fmt_code), .locked(locked));

  function automatic int rate_class(int p);
    if (p < MID_MIN) return 3;
    if (p < SLOW_MIN) return 2;
    return 1;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_line(int p, bit t);
    int d;
    m_fmt = rate_class(p);
    if (t) begin
      m_bi = 0; m_tri = m_tri + 1;
      if (m_tri >= HD_LINES) m_hd = 1;
    end else begin
      m_tri = 0; m_bi = m_bi + 1;
      if (m_bi >= BI_LINES) m_hd = 0;
    end
    d = (p > m_prev_p) ? p - m_prev_p : m_prev_p - p;
    if (m_have_prev && d <= TOL) begin
      m_stable = m_stable + 1;
      if (m_stable >= LOCK_LINES) m_locked = 1;
    end else begin
      m_stable = 0; m_locked = 0;
    end
    m_prev_p = p; m_have_prev = 1;
  endtask

  task automatic check_all(string hd_tag);
    check(hd_n === ~m_hd, hd_tag, int'(hd_n), int'(~m_hd));
    check(fmt_code === 2'(m_fmt), "R7 fmt_code", int'(fmt_code), m_fmt);
    check(locked === m_locked, "R8 R9 locked", int'(locked), int'(m_locked));
  endtask

  // one line: neg_sync rises at offset 0, pos_sync pulse at offset dly if tri
  task automatic send_line(int p, bit tri_on, int dly, string hd_tag);
    bit old_hd;
    old_hd = m_hd;
    if (m_started) model_line(m_last_p, m_prev_tri);
    m_started = 1;
    m_last_p = p;
    m_prev_tri = tri_on && dly >= 1 && dly <= WIN;
    for (int i = 0; i < p; i++) begin
      @(negedge clk);
      if (i == 1) check(hd_n === ~old_hd, "R10 hold", int'(hd_n), int'(~old_hd));
      if (i == 4) check_all(hd_tag);
      neg_sync = (i < PW);
      pos_sync = tri_on && i >= dly && i < dly + PW;
    end
  endtask

  task automatic go_idle();
    repeat (TIMEOUT + 10) begin
      @(negedge clk);
      neg_sync = 0; pos_sync = 0;
    end
    m_started = 0; m_hd = 0; m_locked = 0; m_have_prev = 0;
    m_tri = 0; m_bi = 0; m_stable = 0; m_fmt = 0;
    check_all("R6 hd_n after loss");
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    check(hd_n === 1'b1, "R1 hd_n", int'(hd_n), 1);
    check(fmt_code === 2'd0, "R1 fmt_code", int'(fmt_code), 0);
    check(locked === 1'b0, "R1 locked", int'(locked), 0);
    rst_n = 1;
    @(negedge clk);
    check(hd_n === 1'b1 && locked === 1'b0 && fmt_code === 2'd0, "R1 after release",
          int'({hd_n, locked, fmt_code}), 8);

    // slow bi-level lines: flag stays high, lock builds
    for (int k = 0; k < 30; k++) send_line(420, 0, 0, "R4 slow bi");
    // medium rate bi-level
    for (int k = 0; k < 6; k++) send_line(300, 0, 0, "R4 mid bi");
    // fast graphics-rate bi-level
    for (int k = 0; k < 30; k++) send_line(120, 0, 0, "R4 fast bi");
    go_idle();

    // tri-level: qualification run
    for (int k = 0; k < 20; k++) send_line(150, 1, 3, "R3 tri run");
    // period jump
    send_line(170, 1, 3, "R9 jump");
    for (int k = 0; k < 3; k++) send_line(150, 1, 3, "R9 after jump");
    // window edge: WIN still tri-level
    for (int k = 0; k < 4; k++) send_line(150, 1, WIN, "R2 window edge");
    // just outside the window counts as bi-level
    for (int k = 0; k < BI_LINES + 2; k++) send_line(150, 1, WIN + 1, "R2 R5 outside window");
    // requalify, then fewer than BI_LINES bi-level lines
    for (int k = 0; k < HD_LINES + 2; k++) send_line(150, 1, 1, "R3 requalify");
    for (int k = 0; k < BI_LINES; k++) send_line(150, 0, 0, "R5 short bi run");
    for (int k = 0; k < 3; k++) send_line(150, 0, 0, "R5 bi drop");
    go_idle();

    // constrained random blocks
    for (int b = 0; b < 6; b++) begin
      int base, sel;
      sel = int'($urandom % 3);
      base = (sel == 0) ? 430 : (sel == 1) ? 280 : 140;
      for (int k = 0; k < 24; k++) begin
        int p, dly;
        bit t;
        p = base + int'($urandom % 4);
        t = ($urandom % 8) != 0 ? (b % 2 == 1) : (b % 2 == 0);
        dly = 1 + int'($urandom % (WIN + 3));
        send_line(p, t, dly, "R2 R3 R5 random");
      end
    end
    go_idle();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule